// File: doc/BRIEF.md
# Power-up and reset sequencer

This block owns the power states and the reset tiers of a small system-on-chip. Three active-low reset inputs (power-on, power-fail, user) assert asynchronously and release through two-flop synchronizers. Power-on reset is the top tier. It clears everything, including the preserved real-time-clock registers, through a dedicated clear strobe. It also sets a cold-start status flag and samples the user reset level to latch a test-mode request. Any of the three inputs drives the system reset, which returns the block to Standby.

In Standby the PLL, the CPU and the peripheral run enable are all off. The only way out is a wakeup input. It is listened to only after a long lockout that follows power-on release, and only in Standby. It must also stay high for a minimum number of consecutive synchronized samples. An accepted wakeup turns the PLL on. The CPU is enabled after a settle interval. From Operating, software can force Standby, which re-arms wakeup with no new lockout. Software can also request Idle, which keeps the PLL on, stops the CPU and returns to Operating on an interrupt. All delays are cycle counts of a slow, always-running clock.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While any reset input is low, sys_rst_n is low and pll_en, cpu_en and run are low. sys_rst_n rises two clock edges after the last active reset input is released. The block then rests in Standby with pll_en=0.
- R2: rtc_clr is high while por_n is low and until the power-on release has passed its two-flop synchronizer. Power-fail and user resets never raise it.
- R3: cold_flag (status bit 15) is set to 1 by power-on reset. Other resets leave it unchanged. A cold_clr pulse while power-on reset is released clears it to 0.
- R4: The level of ures_n is captured when the power-on release takes effect. A low level sets test_req to 1 and a high level sets it to 0. test_req does not change after that until the next power-on reset.
- R5: A wakeup is not detected until LOCKOUT_CYC cycles after the synchronized power-on release. With wakeup held high from release, pll_en rises no earlier than LOCKOUT_CYC+2 cycles after release.
- R6: A wakeup is accepted only after DEGLITCH_CYC consecutive high synchronized samples. A pulse shorter than that is rejected, and any low sample restarts the count.
- R7: On acceptance, pll_en rises first. cpu_en and run rise exactly SETTLE_CYC cycles later, when Operating is entered.
- R8: In the settle interval, Operating and Idle, wakeup has no effect on pll_en, cpu_en or run, however it toggles.
- R9: sw_standby in Operating returns to Standby on the next edge (pll_en=cpu_en=run=0). Wakeup is re-armed there without a new lockout.
- R10: sw_idle in Operating enters Idle (pll_en=1, cpu_en=0, run=1). irq in Idle returns to Operating.
- R11: If sw_standby and sw_idle are high in the same Operating cycle, Standby is entered.
- R12: A power-fail or user reset from Operating returns the block to Standby. It does not restart the lockout window, so a held wakeup wakes the block again within a few deglitch intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-running clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pfail_n | input | 1 | Power-fail reset, active low, asynchronous |
| ures_n | input | 1 | User reset, active low, asynchronous; level sampled for test mode |
| wake | input | 1 | Wakeup request, asynchronous |
| sw_standby | input | 1 | Software request to force Standby |
| sw_idle | input | 1 | Software request to enter Idle |
| irq | input | 1 | Interrupt that ends Idle |
| cold_clr | input | 1 | Write-one-to-clear strobe for cold_flag |
| sys_rst_n | output | 1 | Synchronized system reset, active low |
| run | output | 1 | High in Idle and Operating; peripheral enable |
| pll_en | output | 1 | PLL enable |
| cpu_en | output | 1 | CPU enable |
| test_req | output | 1 | Latched test-mode request |
| cold_flag | output | 1 | Cold-start status flag |
| rtc_clr | output | 1 | Clear for registers kept across non-power-on resets |

## Verification
Two software requests, force-Standby and enter-Idle, can arrive in the same Operating cycle. The vector table drives both on one edge and expects pll_en, cpu_en and run all low on the next sample, which is Standby rather than Idle. A second collision pairs a wakeup edge with Operating and Idle residency: table rows raise wake in those states and expect the outputs to stay unchanged. A power-fail reset is also applied while wake is held high, and the time to re-wake is measured to show that the lockout did not restart.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_STBY   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_IDLE   = 2'd3
  } pwr_state_t;

  // true when a counter that started at zero has seen its last cycle of lim
  function automatic bit at_last(int unsigned cnt, int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rel_n = chain[STAGES-1];
endmodule

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter import pwr_seq_pkg::*; #(
  parameter int LOCKOUT_CYC  = 65536,
  parameter int DEGLITCH_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic armed,
  input  logic wake_raw,
  output logic lock_done,
  output logic wake_ok
);
  localparam int LW = $clog2(LOCKOUT_CYC + 1);
  localparam int DW = $clog2(DEGLITCH_CYC + 1);

  logic [1:0]    wsync;
  logic          wake_s;
  logic [LW-1:0] lock_cnt;
  logic [DW-1:0] dg_cnt;
  logic          listen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsync <= '0;
    else        wsync <= {wsync[0], wake_raw};
  end
  assign wake_s = wsync[1];

  // lockout runs once per power-on release; other resets do not restart it
  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok)         lock_cnt <= '0;
    else if (!lock_done) lock_cnt <= lock_cnt + 1'b1;
  end
  assign lock_done = (lock_cnt == LW'(LOCKOUT_CYC));

  assign listen  = armed && lock_done;
  assign wake_ok = listen && wake_s && at_last(int'(dg_cnt), DEGLITCH_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dg_cnt <= '0;
    else if (!listen || !wake_s) dg_cnt <= '0;
    else if (wake_ok)            dg_cnt <= '0;
    else                         dg_cnt <= dg_cnt + 1'b1;
  end

  // R6
  dg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dg_cnt) < DEGLITCH_CYC);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_ok)
    lock_done |=> lock_done);

  // R6
  dg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_s) |=> (dg_cnt == '0));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm import pwr_seq_pkg::*; #(
  parameter int SETTLE_CYC = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_ok,
  input  logic       sw_standby,
  input  logic       sw_idle,
  input  logic       irq,
  output pwr_state_t state,
  output logic       pll_en,
  output logic       cpu_en,
  output logic       run
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  pwr_state_t    nxt;
  logic [SW-1:0] settle_cnt;
  logic          settle_end;

  assign settle_end = at_last(int'(settle_cnt), SETTLE_CYC);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_STBY:   if (wake_ok)    nxt = ST_SETTLE;
      ST_SETTLE: if (settle_end) nxt = ST_RUN;
      ST_RUN: begin
        if (sw_standby)   nxt = ST_STBY;
        else if (sw_idle) nxt = ST_IDLE;
      end
      ST_IDLE:   if (irq)        nxt = ST_RUN;
      default:                   nxt = ST_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_STBY;
      settle_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_SETTLE && !settle_end) settle_cnt <= settle_cnt + 1'b1;
      else                                   settle_cnt <= '0;
    end
  end

  assign pll_en = (state != ST_STBY);
  assign cpu_en = (state == ST_RUN);
  assign run    = (state == ST_RUN) || (state == ST_IDLE);

  // R5
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STBY && !wake_ok) |=> (state == ST_STBY));

  // R7
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE) |-> (int'(settle_cnt) < SETTLE_CYC));

  // R8
  wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN || state == ST_IDLE) |=> (state != ST_SETTLE));

  // R9
  standby_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && sw_standby) |=> (state == ST_STBY));

  // R10
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && irq) |=> (state == ST_RUN));

  // R11
  standby_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && sw_standby && sw_idle) |=> !run);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl import pwr_seq_pkg::*; #(
  parameter int LOCKOUT_CYC  = 65536,
  parameter int DEGLITCH_CYC = 5,
  parameter int SETTLE_CYC   = 8192,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pfail_n,
  input  logic ures_n,
  input  logic wake,
  input  logic sw_standby,
  input  logic sw_idle,
  input  logic irq,
  input  logic cold_clr,
  output logic sys_rst_n,
  output logic run,
  output logic pll_en,
  output logic cpu_en,
  output logic test_req,
  output logic cold_flag,
  output logic rtc_clr
);
  localparam int NTIER = 2;

  logic             any_rst_n;
  logic [NTIER-1:0] tier_src;
  logic [NTIER-1:0] tier_rel;
  logic             por_ok;
  logic             por_ok_d;
  logic             por_edge;
  logic [1:0]       ures_s;
  logic             test_q;
  logic             cold_q;
  logic             lock_done;
  logic             wake_ok;
  pwr_state_t       state;

  assign any_rst_n = por_n & pfail_n & ures_n;
  assign tier_src  = {any_rst_n, por_n};

  for (genvar g = 0; g < NTIER; g++) begin : g_tier
    pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (tier_src[g]),
      .rel_n  (tier_rel[g])
    );
  end

  assign por_ok    = tier_rel[0];
  assign sys_rst_n = tier_rel[1];
  assign rtc_clr   = ~por_ok;

  // user reset level, free-running so it is valid at the power-on release
  always_ff @(posedge clk) ures_s <= {ures_s[0], ures_n};

  assign por_edge = por_ok && !por_ok_d;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_ok_d <= 1'b0;
      test_q   <= 1'b0;
      cold_q   <= 1'b1;
    end else begin
      por_ok_d <= por_ok;
      if (por_edge)           test_q <= ~ures_s[1];
      if (cold_clr && por_ok) cold_q <= 1'b0;
    end
  end

  assign test_req  = test_q;
  assign cold_flag = cold_q;

  pwr_wake_filter #(
    .LOCKOUT_CYC  (LOCKOUT_CYC),
    .DEGLITCH_CYC (DEGLITCH_CYC)
  ) u_wake (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .por_ok    (por_ok),
    .armed     (state == ST_STBY),
    .wake_raw  (wake),
    .lock_done (lock_done),
    .wake_ok   (wake_ok)
  );

  pwr_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .wake_ok    (wake_ok),
    .sw_standby (sw_standby),
    .sw_idle    (sw_idle),
    .irq        (irq),
    .state      (state),
    .pll_en     (pll_en),
    .cpu_en     (cpu_en),
    .run        (run)
  );

  // R2
  rtc_clr_tier_chk: assert property (@(posedge clk) disable iff (!por_n)
    rtc_clr |-> !sys_rst_n);

  // R3
  cold_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!cold_flag) |=> !cold_flag);

  // R4
  test_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    por_ok_d |=> $stable(test_req));

  // R5
  wake_after_lock_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(pll_en) |-> $past(lock_done));
endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int L = 40;
  localparam int D = 4;
  localparam int S = 12;

  logic clk = 1'b0;
  logic por_n, pfail_n, ures_n, wake, sw_standby, sw_idle, irq, cold_clr;
  logic sys_rst_n, run, pll_en, cpu_en, test_req, cold_flag, rtc_clr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.LOCKOUT_CYC(L), .DEGLITCH_CYC(D), .SETTLE_CYC(S)) uut (
    .clk(clk), .por_n(por_n), .pfail_n(pfail_n), .ures_n(ures_n), .wake(wake),
    .sw_standby(sw_standby), .sw_idle(sw_idle), .irq(irq), .cold_clr(cold_clr),
    .sys_rst_n(sys_rst_n), .run(run), .pll_en(pll_en), .cpu_en(cpu_en),
    .test_req(test_req), .cold_flag(cold_flag), .rtc_clr(rtc_clr)
  );

  // {sw_standby, sw_idle, irq, wake, exp_pll, exp_cpu, exp_run}, from Operating
  localparam logic [6:0] VEC [6] = '{
    7'b0001_111,  // R8 wake in Operating ignored
    7'b0100_101,  // R10 enter Idle
    7'b0001_101,  // R8 wake in Idle ignored
    7'b0010_111,  // R10 irq back to Operating
    7'b1100_000,  // R11 both requests: Standby wins
    7'b0000_000   // R9 stays in Standby
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_until_pll(output int n, input int lim);
    n = 0;
    while (!pll_en && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic count_until_cpu(output int n, input int lim);
    n = 0;
    while (!cpu_en && n < lim) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    por_n = 0; pfail_n = 1; ures_n = 0; wake = 0;
    sw_standby = 0; sw_idle = 0; irq = 0; cold_clr = 0;
    cyc(3);
    // R1 reset state
    chk("R1 sys_rst_n in reset", sys_rst_n, 0);
    chk("R1 run/pll/cpu in reset", {run, pll_en, cpu_en}, 0);
    chk("R2 rtc_clr during power-on", rtc_clr, 1);
    chk("R3 cold_flag set", cold_flag, 1);

    // power-on release with user reset low: test mode
    por_n = 1;
    cyc(5);
    chk("R4 test_req with ures low", test_req, 1);
    chk("R2 rtc_clr after release", rtc_clr, 0);
    chk("R1 sys held by user reset", sys_rst_n, 0);
    ures_n = 1;
    cyc(3);
    chk("R1 sys_rst_n released", sys_rst_n, 1);
    chk("R1 standby pll off", pll_en, 0);

    // second power-on with ures high, wake held from the start
    por_n = 0; wake = 1;
    cyc(2);
    chk("R2 rtc_clr on power-on", rtc_clr, 1);
    por_n = 1;
    count_until_pll(n, L + D + 30);
    chk_rng("R5 lockout to pll_en", n, L + 2, L + D + 4);
    chk("R4 test_req with ures high", test_req, 0);
    count_until_cpu(n, S + 20);
    chk("R7 settle cycles", n, S);
    chk("R7 run in Operating", run, 1);
    chk("R3 cold_flag kept", cold_flag, 1);

    // vector table from Operating
    for (int i = 0; i < 6; i++) begin
      {sw_standby, sw_idle, irq, wake} = VEC[i][6:3];
      @(negedge clk);
      sw_standby = 0; sw_idle = 0; irq = 0;
      if ({pll_en, cpu_en, run} != VEC[i][2:0]) begin
        $display("FAIL R8 R10 R11 table row %0d actual=%b expected=%b",
                 i, {pll_en, cpu_en, run}, VEC[i][2:0]);
        errors++;
      end
      checks++;
    end
    wake = 0;

    // R3 clear
    cold_clr = 1; cyc(1); cold_clr = 0; cyc(1);
    chk("R3 cold_flag cleared", cold_flag, 0);

    // R6 short pulse rejected
    wake = 1; cyc(D - 1); wake = 0; cyc(8);
    chk("R6 short pulse rejected", pll_en, 0);
    wake = 1; cyc(D - 1); wake = 0; cyc(1); wake = 1; cyc(D - 1); wake = 0; cyc(8);
    chk("R6 broken pulse rejected", pll_en, 0);
    wake = 1;
    count_until_pll(n, D + 20);
    chk_rng("R9 re-armed without lockout", n, D, D + 4);
    count_until_cpu(n, S + 20);
    chk("R7 cpu after second wake", cpu_en, 1);

    // R12 power-fail while operating, wake held
    pfail_n = 0;
    @(negedge clk);
    chk("R12 power-fail to standby", {run, pll_en, cpu_en}, 0);
    chk("R2 rtc_clr not on power-fail", rtc_clr, 0);
    chk("R3 cold_flag not set by power-fail", cold_flag, 0);
    pfail_n = 1;
    count_until_pll(n, D + 30);
    chk_rng("R12 re-wake without lockout", n, D, D + 8);
    count_until_cpu(n, S + 20);

    // user reset while operating
    ures_n = 0;
    @(negedge clk);
    chk("R1 user reset forces standby", {run, pll_en, cpu_en}, 0);
    chk("R4 test_req unchanged by user reset", test_req, 0);
    chk("R2 rtc_clr not on user reset", rtc_clr, 0);
    ures_n = 1;
    cyc(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule